// File: doc/BRIEF.md
# Cache Maintenance Sequencer with Half-Line Writeback

This block runs maintenance operations on a set-associative write-back cache. It takes one command at a time. Each command is an opcode and a 32-bit operand. The engine then walks the tag array and the data array, which sit outside it as synchronous RAMs, and writes dirty data to memory one word at a time. It updates the tag of every line it touches and pulses `done` when the command has finished.

Each line carries two dirty flags, one for the lower half of the line and one for the upper half. Only the halves marked dirty are written to memory. A line can be selected in three ways:
- by matching a virtual address against the tags of one set;
- by a packed set/way index word;
- by a physical address that is split into way and set fields.

Invalidate-all sweeps the whole array.

Tag word layout:
- bit 0 is the valid flag;
- bit 1 marks the lower half dirty;
- bit 2 marks the upper half dirty;
- bits [31:OFFS] hold the line-aligned virtual address.

OFFS is log2 of the line size in bytes. The physical line address comes from a second word read with the tag.

Both arrays have one cycle of read latency: data asked for in one cycle is valid in the next. Opcodes:

| Opcode | Operation |
|---|---|
| 0 | clean by address |
| 1 | invalidate by address |
| 2 | clean by index |
| 3 | invalidate by index |
| 4 | invalidate all |
| 5 | soft flush |
| 6, 7 | unused |

Top module: `cache_maint_engine`

## Requirements
- R1: After synchronous reset, `cmd_ready` is 1 and `done`, `mem_wr_req`, `tag_we` and `data_re` are 0.
- R2: No memory write and no dirty-flag change happens for a selected line that is invalid (bit 0 clear) or that has both dirty flags (bits 1 and 2) clear.
- R3: With only bit 1 set, exactly the lower half of the words is written, in ascending word order, starting at the line's aligned physical address.
- R4: With only bit 2 set, exactly the upper half of the words is written, starting at the aligned physical address plus half the line size.
- R5: With both dirty bits set, every word of the line is written. After any writeback done by a clean operation, bits 1 and 2 are cleared and the rest of the tag is unchanged.
- R6: Clean by address (opcode 0) scans the ways of set `arg[OFFS +: SET_W]` from way 0 upward. It writes back the first valid way whose tag bits [31:OFFS] equal `arg[31:OFFS]`. On a miss there are no writes and no tag change.
- R7: The invalidating operations (opcodes 1, 3, 4 and 5) write back the selected line and then write its tag to zero. Opcode 1 on a miss changes nothing. No tag write overlaps a pending memory write.
- R8: By-index operations (opcodes 2 and 3) take the way from `arg[31 -: WAY_W]` and the set from `arg[OFFS +: SET_W]`.
- R9: Soft flush (opcode 5) forms `q = arg >> OFFS` and selects way `q[WAY_W-1:0]` and set `q[WAY_W +: SET_W]`.
- R10: Invalidate-all visits sets in ascending order, and ways in ascending order within each set, so memory writes appear in that order.
- R11: Each written word is one request. `mem_wr_req`, `mem_wr_addr` and `mem_wr_data` stay stable until `mem_wr_ack`, and the request drops in the cycle after the acknowledge. Successive addresses of one line step by 4.
- R12: `done` is a single-cycle pulse issued once per command. `cmd_ready` is 0 while a command runs. Opcodes 6 and 7 complete with `done` and no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when cmd_ready is 1 |
| cmd_op | input | 3 | Operation code |
| cmd_arg | input | 32 | Address or index operand |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| done | output | 1 | One-cycle completion pulse |
| tag_re | output | 1 | Tag and physical-address read enable |
| tag_set | output | SET_W | Set address for tag and data arrays |
| tag_way | output | WAY_W | Way address for tag and data arrays |
| tag_rdata | input | 32 | Tag word, valid the cycle after tag_re |
| pa_rdata | input | 32 | Physical line address, valid with tag_rdata |
| tag_we | output | 1 | Tag write enable |
| tag_wdata | output | 32 | Tag write value |
| data_re | output | 1 | Data array read enable |
| data_word | output | WORD_W | Word within the line |
| data_rdata | input | 32 | Data word, valid the cycle after data_re |
| mem_wr_req | output | 1 | Memory word write request |
| mem_wr_addr | output | 32 | Byte address of the word |
| mem_wr_data | output | 32 | Word to write |
| mem_wr_ack | input | 1 | Memory accepted the write |

## Verification
Random array contents give every mix of valid and dirty states. Directed lines with dirty patterns 00, 01, 10 and 11, plus an invalid line with both dirty bits set, separate the four writeback shapes and the skip case.

Address commands are aimed both at resident tags and at random addresses. This tells the hit path apart from the miss path, and shows that the first matching way wins.

Index and soft-flush operands carry random bits outside their fields, so a wrong field slice picks a different line. Randomly delayed acknowledges show whether the request is held, and an invalidate-all sweep checks that the visit order is sets outer, ways inner.

// File: rtl/cme_pkg.sv
package cme_pkg;
  typedef enum logic [2:0] {
    OP_CLEAN_VA   = 3'd0,
    OP_INV_VA     = 3'd1,
    OP_CLEAN_IDX  = 3'd2,
    OP_INV_IDX    = 3'd3,
    OP_INV_ALL    = 3'd4,
    OP_SOFT_FLUSH = 3'd5
  } op_e;

  localparam int VALID_BIT = 0;
  localparam int DLO_BIT   = 1;
  localparam int DHI_BIT   = 2;
  localparam logic [31:0] DIRTY_MASK = 32'h0000_0006;

  typedef enum logic [2:0] {
    S_IDLE, S_TRD, S_TCHK, S_DRD, S_DCAP, S_MEMW, S_NEXT
  } state_e;
endpackage

// File: rtl/cme_line_select.sv
module cme_line_select #(
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  localparam int OFFS  = $clog2(LINE_BYTES),
  localparam int WAY_W = $clog2(WAYS),
  localparam int SET_W = $clog2(SETS)
) (
  input  logic [2:0]       op,
  input  logic [31:0]      arg,
  output logic [SET_W-1:0] set_o,
  output logic [WAY_W-1:0] way_o
);
  import cme_pkg::*;
  logic [31:0] line_no;

  always_comb begin
    line_no = arg >> OFFS;
    set_o   = arg[OFFS +: SET_W];
    way_o   = '0;
    case (op)
      OP_CLEAN_IDX, OP_INV_IDX: way_o = arg[31 -: WAY_W];
      OP_SOFT_FLUSH: begin
        way_o = line_no[WAY_W-1:0];
        set_o = line_no[WAY_W +: SET_W];
      end
      OP_INV_ALL: set_o = '0;
      default: ;
    endcase
  end
endmodule

// File: rtl/cme_wb_plan.sv
module cme_wb_plan #(
  parameter int LINE_BYTES = 32,
  localparam int WORDS  = LINE_BYTES / 4,
  localparam int HALF   = WORDS / 2,
  localparam int OFFS   = $clog2(LINE_BYTES),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic [31:0]       tag,
  input  logic [31:0]       pa,
  output logic              need,
  output logic [WORD_W-1:0] first,
  output logic [WORD_W:0]   count,
  output logic [31:0]       addr
);
  import cme_pkg::*;

  always_comb begin
    need  = tag[VALID_BIT] && (tag[DLO_BIT] || tag[DHI_BIT]);
    first = '0;
    count = (WORD_W+1)'(WORDS);
    case ({tag[DHI_BIT], tag[DLO_BIT]})
      2'b01: count = (WORD_W+1)'(HALF);
      2'b10: begin
        first = WORD_W'(HALF);
        count = (WORD_W+1)'(HALF);
      end
      default: ;
    endcase
    addr = {pa[31:OFFS], {OFFS{1'b0}}} + (32'(first) << 2);
  end
endmodule

// File: rtl/cache_maint_engine.sv
module cache_maint_engine #(
  parameter int LINE_BYTES = 32,
  parameter int WAYS       = 4,
  parameter int SETS       = 16,
  localparam int WORDS  = LINE_BYTES / 4,
  localparam int OFFS   = $clog2(LINE_BYTES),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SET_W  = $clog2(SETS),
  localparam int WORD_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [31:0]       cmd_arg,
  output logic              cmd_ready,
  output logic              done,
  output logic              tag_re,
  output logic [SET_W-1:0]  tag_set,
  output logic [WAY_W-1:0]  tag_way,
  input  logic [31:0]       tag_rdata,
  input  logic [31:0]       pa_rdata,
  output logic              tag_we,
  output logic [31:0]       tag_wdata,
  output logic              data_re,
  output logic [WORD_W-1:0] data_word,
  input  logic [31:0]       data_rdata,
  output logic              mem_wr_req,
  output logic [31:0]       mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  input  logic              mem_wr_ack
);
  import cme_pkg::*;

  state_e            state;
  logic [2:0]        op_q;
  logic [31:0]       arg_q;
  logic [31:0]       tag_q;
  logic [WORD_W:0]   words_left;
  logic [SET_W-1:0]  sel_set;
  logic [WAY_W-1:0]  sel_way;
  logic              plan_need;
  logic [WORD_W-1:0] plan_first;
  logic [WORD_W:0]   plan_count;
  logic [31:0]       plan_addr;
  logic              is_lookup, is_inv, hit, sweep_last;

  cme_line_select #(.LINE_BYTES(LINE_BYTES), .WAYS(WAYS), .SETS(SETS)) u_sel (
    .op(cmd_op), .arg(cmd_arg), .set_o(sel_set), .way_o(sel_way)
  );

  cme_wb_plan #(.LINE_BYTES(LINE_BYTES)) u_plan (
    .tag(tag_rdata), .pa(pa_rdata), .need(plan_need),
    .first(plan_first), .count(plan_count), .addr(plan_addr)
  );

  assign is_lookup  = (op_q == OP_CLEAN_VA) || (op_q == OP_INV_VA);
  assign is_inv     = (op_q == OP_INV_VA) || (op_q == OP_INV_IDX) ||
                      (op_q == OP_INV_ALL) || (op_q == OP_SOFT_FLUSH);
  assign hit        = tag_rdata[VALID_BIT] && (tag_rdata[31:OFFS] == arg_q[31:OFFS]);
  assign sweep_last = (tag_way == WAY_W'(WAYS-1)) && (tag_set == SET_W'(SETS-1));
  assign cmd_ready  = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      op_q        <= '0;
      arg_q       <= '0;
      tag_q       <= '0;
      words_left  <= '0;
      done        <= 1'b0;
      tag_re      <= 1'b0;
      tag_we      <= 1'b0;
      data_re     <= 1'b0;
      mem_wr_req  <= 1'b0;
      tag_set     <= '0;
      tag_way     <= '0;
      tag_wdata   <= '0;
      data_word   <= '0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      done    <= 1'b0;
      tag_re  <= 1'b0;
      tag_we  <= 1'b0;
      data_re <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q  <= cmd_op;
          arg_q <= cmd_arg;
          if (cmd_op > OP_SOFT_FLUSH) begin
            done <= 1'b1;
          end else begin
            tag_set <= sel_set;
            tag_way <= sel_way;
            tag_re  <= 1'b1;
            state   <= S_TRD;
          end
        end
        S_TRD: state <= S_TCHK;
        S_TCHK: begin
          if (is_lookup && !hit) begin
            if (tag_way == WAY_W'(WAYS-1)) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              tag_way <= tag_way + 1'b1;
              tag_re  <= 1'b1;
              state   <= S_TRD;
            end
          end else begin
            tag_q <= tag_rdata;
            if (plan_need) begin
              data_word   <= plan_first;
              words_left  <= plan_count;
              mem_wr_addr <= plan_addr;
              data_re     <= 1'b1;
              state       <= S_DRD;
            end else begin
              if (is_inv) begin
                tag_we    <= 1'b1;
                tag_wdata <= '0;
              end
              state <= S_NEXT;
            end
          end
        end
        S_DRD: state <= S_DCAP;
        S_DCAP: begin
          mem_wr_req  <= 1'b1;
          mem_wr_data <= data_rdata;
          state       <= S_MEMW;
        end
        S_MEMW: if (mem_wr_ack) begin
          mem_wr_req <= 1'b0;
          if (words_left == (WORD_W+1)'(1)) begin
            tag_we    <= 1'b1;
            tag_wdata <= is_inv ? '0 : (tag_q & ~DIRTY_MASK);
            state     <= S_NEXT;
          end else begin
            words_left  <= words_left - 1'b1;
            data_word   <= data_word + 1'b1;
            mem_wr_addr <= mem_wr_addr + 32'd4;
            data_re     <= 1'b1;
            state       <= S_DRD;
          end
        end
        S_NEXT: begin
          if (op_q == OP_INV_ALL && !sweep_last) begin
            if (tag_way == WAY_W'(WAYS-1)) begin
              tag_way <= '0;
              tag_set <= tag_set + 1'b1;
            end else begin
              tag_way <= tag_way + 1'b1;
            end
            tag_re <= 1'b1;
            state  <= S_TRD;
          end else begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cme_checker.sv
module cme_checker (
  input logic        clk,
  input logic        rst,
  input logic        cmd_ready,
  input logic        done,
  input logic        tag_we,
  input logic        data_re,
  input logic        mem_wr_req,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data,
  input logic        mem_wr_ack
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (cmd_ready && !done && !mem_wr_req && !tag_we && !data_re));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_ack) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_req_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && mem_wr_ack) |=> !mem_wr_req);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> !mem_wr_req);

  p_tag_after_wr_r7: assert property (@(posedge clk) disable iff (rst)
    tag_we |-> !mem_wr_req);
endmodule

bind cache_maint_engine cme_checker u_chk (
  .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .done(done), .tag_we(tag_we),
  .data_re(data_re), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
);

// File: tb/tb_cache_maint_engine.sv
`timescale 1ns/1ps
module tb_cache_maint_engine;
  localparam int LB = 32, WAYS = 4, SETS = 16;
  localparam int WORDS = LB / 4, HALF = WORDS / 2;
  localparam int OFFS = $clog2(LB), WAY_W = $clog2(WAYS), SET_W = $clog2(SETS);
  localparam int WORD_W = $clog2(WORDS), LINES = WAYS * SETS;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [31:0] cmd_arg = 0;
  logic cmd_ready, done, tag_re, tag_we, data_re, mem_wr_req;
  logic mem_wr_ack = 0;
  logic [SET_W-1:0] tag_set;
  logic [WAY_W-1:0] tag_way;
  logic [WORD_W-1:0] data_word;
  logic [31:0] tag_rdata = 0, pa_rdata = 0, data_rdata = 0;
  logic [31:0] tag_wdata, mem_wr_addr, mem_wr_data;

  always #2 clk = ~clk;

  cache_maint_engine #(.LINE_BYTES(LB), .WAYS(WAYS), .SETS(SETS)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .cmd_ready(cmd_ready), .done(done), .tag_re(tag_re), .tag_set(tag_set),
    .tag_way(tag_way), .tag_rdata(tag_rdata), .pa_rdata(pa_rdata), .tag_we(tag_we),
    .tag_wdata(tag_wdata), .data_re(data_re), .data_word(data_word),
    .data_rdata(data_rdata), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  logic [31:0] tagm [LINES];
  logic [31:0] pam  [LINES];
  logic [31:0] datm [LINES*WORDS];
  logic [31:0] ref_tag [LINES];
  logic [31:0] log_a [1024];
  logic [31:0] log_d [1024];
  logic [31:0] exp_a [1024];
  logic [31:0] exp_d [1024];
  int log_n = 0, exp_n = 0, wait_cnt = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always @(posedge clk) begin
    if (tag_re) begin
      tag_rdata <= tagm[int'(tag_set)*WAYS + int'(tag_way)];
      pa_rdata  <= pam[int'(tag_set)*WAYS + int'(tag_way)];
    end
    if (tag_we) tagm[int'(tag_set)*WAYS + int'(tag_way)] <= tag_wdata;
    if (data_re)
      data_rdata <= datm[(int'(tag_set)*WAYS + int'(tag_way))*WORDS + int'(data_word)];
    if (mem_wr_req && !mem_wr_ack) begin
      if (wait_cnt == 0) begin
        mem_wr_ack <= 1'b1;
        if (log_n < 1024) begin
          log_a[log_n] <= mem_wr_addr;
          log_d[log_n] <= mem_wr_data;
        end
        log_n    <= log_n + 1;
        wait_cnt <= int'($urandom % 3);
      end else wait_cnt <= wait_cnt - 1;
    end else mem_wr_ack <= 1'b0;
  end

  task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
    end
  endtask

  function automatic int find_way(logic [31:0] va);
    int s = int'(va[OFFS +: SET_W]);
    for (int w = 0; w < WAYS; w++)
      if (ref_tag[s*WAYS+w][0] && ref_tag[s*WAYS+w][31:OFFS] == va[31:OFFS]) return w;
    return -1;
  endfunction

  task automatic exp_line(int li, bit inv);
    logic [31:0] t = ref_tag[li];
    int first, cnt;
    if (t[0] && t[2:1] != 2'b00) begin
      first = (t[2:1] == 2'b10) ? HALF : 0;
      cnt   = (t[2:1] == 2'b11) ? WORDS : HALF;
      for (int k = 0; k < cnt; k++) begin
        exp_a[exp_n] = {pam[li][31:OFFS], {OFFS{1'b0}}} + 32'((first + k) * 4);
        exp_d[exp_n] = datm[li*WORDS + first + k];
        exp_n++;
      end
      ref_tag[li] = t & ~32'h6;
    end
    if (inv) ref_tag[li] = 32'h0;
  endtask

  task automatic run_cmd(logic [2:0] op, logic [31:0] arg, string rq);
    int n = 0, bad = 0, w;
    exp_n = 0;
    case (op)
      3'd0, 3'd1: begin
        w = find_way(arg);
        if (w >= 0) exp_line(int'(arg[OFFS +: SET_W])*WAYS + w, op == 3'd1);
      end
      3'd2, 3'd3: exp_line(int'(arg[OFFS +: SET_W])*WAYS + int'(arg[31 -: WAY_W]), op == 3'd3);
      3'd4: for (int li = 0; li < LINES; li++) exp_line(li, 1'b1);
      3'd5: begin
        logic [31:0] q = arg >> OFFS;
        exp_line(int'(q[WAY_W +: SET_W])*WAYS + int'(q[WAY_W-1:0]), 1'b1);
      end
      default: ;
    endcase
    log_n = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 0;
    if (op <= 3'd5) check(!cmd_ready, "R12", "ready during command", 32'(cmd_ready), 0);
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done, "R12", "done seen", 32'(done), 1);
    @(negedge clk);
    check(!done, "R12", "done one cycle", 32'(done), 0);
    check(log_n == exp_n, rq, "write count", 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      check(log_a[i] == exp_a[i], rq, "write addr", log_a[i], exp_a[i]);
      check(log_d[i] == exp_d[i], rq, "write data", log_d[i], exp_d[i]);
    end
    for (int li = 0; li < LINES; li++) if (tagm[li] != ref_tag[li]) bad = li + 1;
    if (bad > 0) check(0, rq, "tag array", tagm[bad-1], ref_tag[bad-1]);
    else check(1, rq, "tag array", 0, 0);
  endtask

  task automatic fill_all();
    for (int li = 0; li < LINES; li++) begin
      logic [31:0] t = $urandom;
      t[OFFS +: SET_W] = SET_W'(li / WAYS);
      t[OFFS-1:3] = '0;
      tagm[li] = t; ref_tag[li] = t;
      pam[li] = $urandom & ~32'(LB - 1);
      for (int k = 0; k < WORDS; k++) datm[li*WORDS+k] = $urandom;
    end
  endtask

  task automatic set_line(int li, logic [2:0] st);
    tagm[li] = {tagm[li][31:3], st};
    ref_tag[li] = tagm[li];
  endtask

  function automatic logic [31:0] idx_arg(int s, int w);
    logic [31:0] a = $urandom;
    a[31 -: WAY_W] = WAY_W'(w);
    a[OFFS +: SET_W] = SET_W'(s);
    return a;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    fill_all();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready && !done && !mem_wr_req && !tag_we && !data_re, "R1", "reset outputs",
          {27'd0, cmd_ready, done, mem_wr_req, tag_we, data_re}, 32'h10);
    // directed: dirty shapes via clean by index (R8)
    set_line(5*WAYS+1, 3'b011); run_cmd(3'd2, idx_arg(5, 1), "R3");
    set_line(6*WAYS+2, 3'b101); run_cmd(3'd2, idx_arg(6, 2), "R4");
    set_line(7*WAYS+3, 3'b111); run_cmd(3'd2, idx_arg(7, 3), "R5");
    set_line(8*WAYS+0, 3'b001); run_cmd(3'd2, idx_arg(8, 0), "R2");
    set_line(9*WAYS+1, 3'b110); run_cmd(3'd2, idx_arg(9, 1), "R2");
    set_line(3*WAYS+2, 3'b111); run_cmd(3'd3, idx_arg(3, 2), "R8");
    // by address: hit, invalidate hit, miss
    set_line(10*WAYS+3, 3'b111);
    run_cmd(3'd0, {tagm[10*WAYS+3][31:OFFS], 5'd7}, "R6");
    set_line(11*WAYS+2, 3'b011);
    run_cmd(3'd1, {tagm[11*WAYS+2][31:OFFS], 5'd3}, "R7");
    run_cmd(3'd1, 32'hFFFF_FFE0 ^ {tagm[12*WAYS][31:OFFS], 5'd0}, "R7");
    run_cmd(3'd0, 32'h0000_0140, "R6");
    // soft flush
    set_line(13*WAYS+1, 3'b111);
    run_cmd(3'd5, 32'hA000_0000 | 32'((13*WAYS+1)*LB + 12), "R9");
    // unused opcodes
    run_cmd(3'd6, $urandom, "R12");
    run_cmd(3'd7, $urandom, "R12");
    // random mix
    for (int i = 0; i < 60; i++) begin
      int r = int'($urandom % 6);
      int li = int'($urandom % LINES);
      case (r)
        0, 1: run_cmd(3'(r), ($urandom % 2) ? {tagm[li][31:OFFS], 5'(($urandom))} : $urandom, "R6");
        2, 3: run_cmd(3'(r), idx_arg(li / WAYS, li % WAYS), "R8");
        default: run_cmd(3'd5, ($urandom << (OFFS+WAY_W+SET_W)) | 32'(li*LB) | ($urandom % LB), "R9");
      endcase
      if (i % 10 == 9) begin
        // re-seed part of the array so dirty lines keep appearing
        for (int k = 0; k < LINES; k += 3) set_line(k, 3'($urandom) | 3'b001);
      end
    end
    // sweep order, then everything must be zero
    fill_all();
    run_cmd(3'd4, 32'd0, "R10");
    run_cmd(3'd2, idx_arg(2, 2), "R2");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R12 watchdog: actual %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule